// File: doc/BRIEF.md
# Reloading Interval Timer

A 16-bit interval timer that counts down once per clock cycle from a value held in a programmable latch. In continuous mode it refills itself from the latch on every underflow and keeps running with no help from software. In one-shot mode it refills once and then stops. Each underflow sets an interrupt flag. The flag drives an interrupt line through a mask bit and stays set until software reads the status register.

The counter never shows zero. The cycle in which zero would appear shows the refilled latch value instead, so the latch value is visible for two cycles in a row and the period is the latch value plus one. A build parameter selects one of two silicon revisions. The revisions have the same period and differ only in the cycle in which the flag is raised: the early revision raises it in the same cycle as the refill, and the late revision raises it one cycle after.

Software uses four byte-wide registers selected by `addr`. Register 0 is the low byte: a write sets the latch low byte and a read returns the counter low byte. Register 1 is the high byte: a write sets the latch high byte and a read returns the counter high byte. Register 2 is control. Register 3 holds the interrupt status and mask. Reads are combinational on `addr`.

Top module: `ivtimer`

## Requirements
- R1: After reset the counter and the latch hold all ones, the run and one-shot bits are 0, the flag and mask are 0, and `irq` is low. Reads give 0xFF at addresses 0 and 1 and 0x00 at addresses 2 and 3.
- R2: Writing address 1 while the timer is stopped loads the counter from {written byte, latch low byte} at the next edge. Writing address 0 never loads the counter. Writing address 1 while the timer is running changes only the latch, and the new latch value is used at the next refill.
- R3: A write that sets control bit 0 (run) starts the decrement at the edge after the write edge. While running, the counter drops by one per cycle and the borrow carries across the byte boundary. While stopped, the counter holds its value.
- R4: In continuous mode (control bit 1 = 0) with latch L ≥ 1, per-cycle reads give L, L-1, …, 1, L, L, L-1, …. Zero never appears and the period is L+1 cycles.
- R5: Writing control with bit 4 set copies the latch into the counter at the next edge. Bit 4 always reads back as 0.
- R6: In one-shot mode (control bit 1 = 1), the underflow refills the counter from the latch and clears the run bit, and the counter then holds. The one-shot bit keeps its value.
- R7: With REVISION=1 the flag becomes visible in the first cycle that shows the refilled latch value. With REVISION=0 it becomes visible one cycle later. Both revisions have the same period.
- R8: Address 3 reads as bit 0 = flag, bit 1 = mask, bit 7 = `irq`. A read with `rd_en` high clears the flag at the next edge. A read without `rd_en` does not clear it. A write to address 3 sets the mask from bit 1.
- R9: `irq` is high exactly when both the flag and the mask are set. With the mask at 0, the line stays low even while the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter steps once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 3 clears the flag |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt line, flag ANDed with mask |

## Verification
The checker runs on every cycle and covers these properties:
- the counter holds while stopped and steps down by exactly one while running;
- a running counter never reaches zero unless it is refilled from a zero latch;
- a force load lands the latch in the counter;
- a one-shot underflow drops the run bit;
- the flag rises only from the event that the selected revision allows;
- a clearing read with no competing set empties the flag, and the line is low whenever the mask is low.

Only the bench scenarios can show the exact repeating read sequence with the doubled latch value and the one-cycle offset between the two revisions running side by side. The same holds for which latch writes do or do not reach the counter, and for the borrow from the high byte.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_INT  = 2'd3
    } reg_sel_e;

    // control byte bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_ONE   = 1;
    localparam int CB_FORCE = 4;

    // status byte bit positions
    localparam int SB_FLAG = 0;
    localparam int SB_MASK = 1;
    localparam int SB_LINE = 7;

    typedef struct packed {
        logic oneshot;
        logic run;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(input ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[CB_RUN] = c.run;
        b[CB_ONE] = c.oneshot;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic flag,
                                                      input logic mask,
                                                      input logic line);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[SB_FLAG] = flag;
        b[SB_MASK] = mask;
        b[SB_LINE] = line;
        return b;
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              run_clear,
    output logic [CNT_W-1:0]  latch,
    output ctrl_t             ctrl,
    output logic              mask,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val
);

    logic [DATA_W-1:0] lat_lo, lat_hi;
    logic lo_wr, hi_wr, ctl_wr, int_wr;

    assign lo_wr  = wr_en && (reg_sel_e'(addr) == SEL_LO);
    assign hi_wr  = wr_en && (reg_sel_e'(addr) == SEL_HI);
    assign ctl_wr = wr_en && (reg_sel_e'(addr) == SEL_CTRL);
    assign int_wr = wr_en && (reg_sel_e'(addr) == SEL_INT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo <= '1;
            lat_hi <= '1;
            ctrl   <= '0;
            mask   <= 1'b0;
        end else begin
            if (lo_wr) lat_lo <= wr_data;
            if (hi_wr) lat_hi <= wr_data;
            if (ctl_wr) begin
                ctrl.run     <= wr_data[CB_RUN];
                ctrl.oneshot <= wr_data[CB_ONE];
            end else if (run_clear) begin
                ctrl.run <= 1'b0;
            end
            if (int_wr) mask <= wr_data[SB_MASK];
        end
    end

    assign latch = {lat_hi, lat_lo};

    // high-byte write while stopped, or explicit force bit
    assign load_req = (hi_wr && !ctrl.run) || (ctl_wr && wr_data[CB_FORCE]);
    assign load_val = hi_wr ? {wr_data, lat_lo} : latch;

endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch,
    output logic [CNT_W-1:0] cnt,
    output logic             under,
    output logic             reload_q
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(1);

    // underflow point: last counted value, next edge refills
    assign under = run && !reload_q && (cnt <= FLOOR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '1;
            reload_q <= 1'b0;
        end else if (load_req) begin
            cnt      <= load_val;
            reload_q <= 1'b0;
        end else if (run) begin
            if (reload_q) begin
                reload_q <= 1'b0;          // latch value shown a second time
            end else if (under) begin
                cnt      <= latch;
                reload_q <= 1'b1;
            end else begin
                cnt <= cnt - FLOOR;
            end
        end else begin
            reload_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
    parameter int REVISION = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic under,
    input  logic reload_q,
    input  logic clr_req,
    input  logic mask,
    output logic flag,
    output logic irq
);

    logic set_evt;

    generate
        if (REVISION != 0) begin : g_early
            assign set_evt = under;
        end else begin : g_late
            assign set_evt = reload_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    assign irq = flag & mask;

endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int REVISION = 0,
    parameter int DATA_W   = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] latch_q, load_val, cnt_q;
    ctrl_t            ctrl_q;
    logic             mask_q, load_req, under, reload_q, flag_q;
    logic             run_q, one_q, run_clear, clr_req;

    assign run_q     = ctrl_q.run;
    assign one_q     = ctrl_q.oneshot;
    assign run_clear = under && one_q;
    assign clr_req   = rd_en && (reg_sel_e'(addr) == SEL_INT);

    ivt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .run_clear(run_clear),
        .latch    (latch_q),
        .ctrl     (ctrl_q),
        .mask     (mask_q),
        .load_req (load_req),
        .load_val (load_val)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .load_req(load_req),
        .load_val(load_val),
        .latch   (latch_q),
        .cnt     (cnt_q),
        .under   (under),
        .reload_q(reload_q)
    );

    ivt_irq #(.REVISION(REVISION)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .under   (under),
        .reload_q(reload_q),
        .clr_req (clr_req),
        .mask    (mask_q),
        .flag    (flag_q),
        .irq     (irq)
    );

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_LO:   rd_data = cnt_q[DATA_W-1:0];
            SEL_HI:   rd_data = cnt_q[CNT_W-1:DATA_W];
            SEL_CTRL: rd_data = DATA_W'(ctrl_byte(ctrl_q));
            SEL_INT:  rd_data = DATA_W'(status_byte(flag_q, mask_q, irq));
        endcase
    end

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
    parameter int REVISION = 0,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  latch_q,
    input logic              run_q,
    input logic              one_q,
    input logic              load_req,
    input logic              under,
    input logic              reload_q,
    input logic              flag_q,
    input logic              mask_q,
    input logic              irq
);

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !load_req) |=> $stable(cnt_q));

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !load_req && !reload_q && cnt_q > CNT_W'(1))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !load_req && cnt_q != '0 && latch_q != '0) |=> (cnt_q != '0));

    // R5
    force_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2 && wr_data[4]) |=> (cnt_q == $past(latch_q)));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (under && one_q && !(wr_en && addr == 2'd2)) |=> !run_q);

    generate
        if (REVISION != 0) begin : g_early
            // R7
            early_set_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_q) |-> $past(under));
        end else begin : g_late
            // R7
            late_set_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(flag_q) |-> $past(reload_q));
        end
    endgenerate

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd3 && !under && !reload_q) |=> !flag_q);

    // R9
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!mask_q || !flag_q) |-> !irq);

endmodule

bind ivtimer ivt_chk #(.REVISION(REVISION), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .cnt_q   (cnt_q),
    .latch_q (latch_q),
    .run_q   (run_q),
    .one_q   (one_q),
    .load_req(load_req),
    .under   (under),
    .reload_q(reload_q),
    .flag_q  (flag_q),
    .mask_q  (mask_q),
    .irq     (irq)
);

// File: tb/sim_ivtimer.sv
`timescale 1ns/1ps
module sim_ivtimer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd0, rd1;
    logic       irq0, irq1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         dut;
        bit         is_irq;
        logic [7:0] val;
        string      tag;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;

    // late-flag revision
    ivtimer #(.REVISION(0)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd0), .irq(irq0)
    );

    // early-flag revision, same stimulus
    ivtimer #(.REVISION(1)) u1 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd1), .irq(irq1)
    );

    task automatic drive(input logic [1:0] a, input logic we,
                         input logic [7:0] d, input logic re);
        @(negedge clk);
        addr = a; wr_en = we; wr_data = d; rd_en = re;
    endtask

    task automatic push(input int dut, input bit is_irq,
                        input logic [7:0] v, input string tag);
        item_t it;
        it.dut = dut; it.is_irq = is_irq; it.val = v; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic push_both(input logic [7:0] v, input string tag);
        push(0, 1'b0, v, tag);
        push(1, 1'b0, v, tag);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: compare queued expectations just before the next rising edge
    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        #1;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            if (it.is_irq) act = {7'd0, (it.dut == 0) ? irq0 : irq1};
            else           act = (it.dut == 0) ? rd0 : rd1;
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s u%0d %s: actual=%h expected=%h",
                         it.tag, it.dut, it.is_irq ? "irq" : "rd_data", act, it.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        drive(2'd0, 0, 8'h00, 0); push_both(8'hFF, "R1");
        drive(2'd1, 0, 8'h00, 0); push_both(8'hFF, "R1");
        drive(2'd2, 0, 8'h00, 0); push_both(8'h00, "R1");
        drive(2'd3, 0, 8'h00, 0); push_both(8'h00, "R1");
        push(0, 1'b1, 8'h00, "R1"); push(1, 1'b1, 8'h00, "R1");

        // continuous, latch 5, mask on
        drive(2'd0, 1, 8'd5, 0);
        drive(2'd1, 1, 8'd0, 0);
        drive(2'd3, 1, 8'h02, 0);
        drive(2'd2, 1, 8'h01, 0);
        for (int i = 0; i < 12; i++) begin
            int m;
            logic [7:0] v;
            m = i % 6;
            v = (m == 5) ? 8'd5 : 8'(5 - m);
            drive(2'd0, 0, 8'h00, 0);
            push_both(v, (i == 0) ? "R3" : "R4");
            push(0, 1'b1, (i >= 6) ? 8'h01 : 8'h00, "R7");
            push(1, 1'b1, (i >= 5) ? 8'h01 : 8'h00, "R7");
        end
        drive(2'd2, 1, 8'h00, 0);               // stop
        drive(2'd3, 0, 8'h00, 0); push_both(8'h83, "R8");
        drive(2'd3, 0, 8'h00, 1); push_both(8'h83, "R8");
        drive(2'd3, 0, 8'h00, 0); push_both(8'h02, "R8");
        push(0, 1'b1, 8'h00, "R8"); push(1, 1'b1, 8'h00, "R8");
        drive(2'd0, 0, 8'h00, 0); push_both(8'd4, "R3");
        drive(2'd0, 0, 8'h00, 0); push_both(8'd4, "R3");

        // one-shot, force load, mask off
        drive(2'd3, 1, 8'h00, 0);
        drive(2'd0, 1, 8'd3, 0);
        drive(2'd2, 1, 8'h10, 0);
        drive(2'd0, 0, 8'h00, 0); push_both(8'd3, "R5");
        drive(2'd2, 0, 8'h00, 0); push_both(8'h00, "R5");
        drive(2'd2, 1, 8'h03, 0);               // run + one-shot
        drive(2'd1, 1, 8'd0, 0);                // high write while running
        drive(2'd0, 1, 8'd7, 0); push_both(8'd2, "R2");
        drive(2'd0, 0, 8'h00, 0); push_both(8'd1, "R6");
        push(0, 1'b1, 8'h00, "R9"); push(1, 1'b1, 8'h00, "R9");
        drive(2'd3, 0, 8'h00, 0);
        push(0, 1'b0, 8'h00, "R7"); push(1, 1'b0, 8'h01, "R7");
        drive(2'd0, 0, 8'h00, 0); push_both(8'd7, "R6");
        push(0, 1'b1, 8'h00, "R9"); push(1, 1'b1, 8'h00, "R9");
        drive(2'd0, 0, 8'h00, 0); push_both(8'd7, "R6");
        drive(2'd2, 0, 8'h00, 0); push_both(8'h02, "R6");
        drive(2'd3, 0, 8'h00, 0); push_both(8'h01, "R9");
        push(0, 1'b1, 8'h00, "R9"); push(1, 1'b1, 8'h00, "R9");
        drive(2'd3, 0, 8'h00, 0); push_both(8'h01, "R8");

        // latch byte writes while stopped
        drive(2'd0, 1, 8'h34, 0);
        drive(2'd0, 0, 8'h00, 0); push_both(8'd7, "R2");
        drive(2'd1, 1, 8'h12, 0);
        drive(2'd0, 0, 8'h00, 0); push_both(8'h34, "R2");
        drive(2'd1, 0, 8'h00, 0); push_both(8'h12, "R2");

        // borrow across the byte boundary
        drive(2'd0, 1, 8'h00, 0);
        drive(2'd1, 1, 8'h01, 0);
        drive(2'd2, 1, 8'h01, 0);
        drive(2'd1, 0, 8'h00, 0); push_both(8'h01, "R3");
        drive(2'd0, 0, 8'h00, 0); push_both(8'hFF, "R3");
        drive(2'd1, 0, 8'h00, 0); push_both(8'h00, "R3");

        drive(2'd0, 0, 8'h00, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule